// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Checker

This block is the issue-stage control of an in-order pipeline that fetches a 64-bit packet each cycle. Each packet holds two 32-bit instructions. The lower-address slot is reserved for ALU and branch work, and the upper-address slot for memory access. The block decodes both slots and looks for two things: a register dependency from the ALU slot to the memory slot of the same packet, and a packet that reads the destination of a load issued in the cycle before. It then decides whether the packet issues whole, issues as two halves over two cycles, or waits.

The fetch unit presents a packet with `pkt_valid_i`. While `hold_o` is high it must present the same packet again in the next cycle. The fetch PC moves forward by `pc_adv_o` bytes on each cycle. The two issue outputs tell the execution lanes which slots start in the current cycle. A packet whose slots do not match the required types is flagged, and it still issues as it stands.

Top module: `dual_issue_ctrl`

## Requirements
- R1: Slot 0 is `pkt_i[31:0]` and slot 1 is `pkt_i[63:32]`. An all-zero instruction is a nop, and a nop slot never asserts its issue output (`issue_alu_o` for slot 0, `issue_mem_o` for slot 1).
- R2: The opcode is bits [31:26]. Opcodes 0x23 (load) and 0x2B (store) are memory class. Opcodes 0x00, 0x01, 0x04–0x07 (branches) and 0x08–0x0F (immediate ALU) are ALU/branch class. `illegal_o` is high when slot 0 holds a non-nop, non-ALU/branch instruction, or when slot 1 holds a non-nop, non-memory instruction. Such a packet is still issued under the same rules.
- R3: A valid packet with no hazard issues both non-nop slots in the same cycle, with `hold_o` low and `pc_adv_o` equal to 8.
- R4: Slot 0 writes a register: rd (bits [15:11]) for opcode 0, or rt (bits [20:16]) for opcodes 0x08–0x0F. If slot 1 reads that register, the packet is split. Slot 1 reads its base rs (bits [25:21]) and, for a store, its data rt. In the first cycle only `issue_alu_o` is high, `hold_o` is high and `pc_adv_o` is 0. In the next valid cycle only slot 1 issues, `hold_o` is low and `pc_adv_o` is 8.
- R5: A load issued from slot 1 has destination rt. If the packet in the next cycle reads that register from either slot, nothing issues, `hold_o` is high and `pc_adv_o` is 0. In the cycle after that the packet proceeds normally.
- R6: Register 0 never creates an intra-packet or load-use dependency.
- R7: When `pkt_valid_i` is low, no issue, hold, illegal flag or PC advance is produced. Such a cycle also ends the one-cycle load latency.
- R8: Asynchronous reset clears any pending split and any recorded load destination.
- R9: Branches write no register. They read rs (opcodes 0x01, 0x06, 0x07) or rs and rt (0x04, 0x05), and those reads count toward load-use stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pkt_valid_i | input | 1 | Fetched packet present |
| pkt_i | input | 64 | Two-instruction packet, slot 0 in the low half |
| issue_alu_o | output | 1 | ALU/branch slot issues this cycle |
| issue_mem_o | output | 1 | Load/store slot issues this cycle |
| hold_o | output | 1 | Fetch must present the same packet next cycle |
| pc_adv_o | output | 4 | Bytes to advance the fetch PC (0 or 8) |
| illegal_o | output | 1 | Slot contents violate the slot-type rule |

## Verification
The bench builds the block with its default 32-bit instruction and 5-bit register fields. With those widths, two-instruction packets map straight onto the 64-bit fetch word. Random register numbers are drawn from r0 to r3, so intra-packet dependencies, load-use collisions and register-0 exemptions occur often. A replayed four-way unrolled loop schedule contains one planned split, so both the cycle count and the number of instructions issued per iteration can be predicted.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_AW  = 5;
  localparam int OPC_W   = 6;
  localparam int N_SLOT  = 2;
  localparam int PKT_W   = INSTR_W * N_SLOT;
  localparam int PC_STEP = PKT_W / 8;
  localparam int PC_W    = $clog2(PC_STEP) + 1;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

  typedef enum logic [2:0] {
    CLS_NOP, CLS_ALU, CLS_BR, CLS_LD, CLS_ST, CLS_BAD
  } slot_cls_e;

  typedef struct packed {
    slot_cls_e         cls;
    logic              wr_en;
    logic [REG_AW-1:0] wr_reg;
    logic              ra_en;
    logic [REG_AW-1:0] ra;
    logic              rb_en;
    logic [REG_AW-1:0] rb;
  } slot_info_t;
endpackage

// File: rtl/slot_decoder.sv
module slot_decoder
  import dual_issue_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output slot_info_t         info_o
);
  logic [OPC_W-1:0]  opc;
  logic [REG_AW-1:0] rs, rt, rd;

  assign opc = instr_i[31:26];
  assign rs  = instr_i[25:21];
  assign rt  = instr_i[20:16];
  assign rd  = instr_i[15:11];

  always_comb begin
    info_o        = '0;
    info_o.cls    = CLS_BAD;
    info_o.ra     = rs;
    info_o.rb     = rt;
    info_o.wr_reg = rt;
    if (instr_i == '0) begin
      info_o.cls = CLS_NOP;
    end else begin
      unique case (opc)
        OPC_RTYPE: begin
          info_o.cls    = CLS_ALU;
          info_o.wr_en  = 1'b1;
          info_o.wr_reg = rd;
          info_o.ra_en  = 1'b1;
          info_o.rb_en  = 1'b1;
        end
        6'h01, 6'h06, 6'h07: begin
          info_o.cls   = CLS_BR;
          info_o.ra_en = 1'b1;
        end
        6'h04, 6'h05: begin
          info_o.cls   = CLS_BR;
          info_o.ra_en = 1'b1;
          info_o.rb_en = 1'b1;
        end
        6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E: begin
          info_o.cls   = CLS_ALU;
          info_o.wr_en = 1'b1;
          info_o.ra_en = 1'b1;
        end
        6'h0F: begin
          info_o.cls   = CLS_ALU;
          info_o.wr_en = 1'b1;
        end
        OPC_LOAD: begin
          info_o.cls   = CLS_LD;
          info_o.wr_en = 1'b1;
          info_o.ra_en = 1'b1;
        end
        OPC_STORE: begin
          info_o.cls   = CLS_ST;
          info_o.ra_en = 1'b1;
          info_o.rb_en = 1'b1;
        end
        default: info_o.cls = CLS_BAD;
      endcase
      // r0 is hardwired: never a producer or consumer
      if (info_o.wr_reg == '0) info_o.wr_en = 1'b0;
      if (info_o.ra == '0)     info_o.ra_en = 1'b0;
      if (info_o.rb == '0)     info_o.rb_en = 1'b0;
    end
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import dual_issue_pkg::*;
(
  input  slot_info_t        alu_slot_i,
  input  slot_info_t        mem_slot_i,
  input  logic              ld_v_i,
  input  logic [REG_AW-1:0] ld_reg_i,
  input  logic              split_q_i,
  output logic              intra_dep_o,
  output logic              load_use_o,
  output logic              illegal_o
);
  function automatic logic reads_reg(slot_info_t s, logic [REG_AW-1:0] r);
    return (s.ra_en && s.ra == r) || (s.rb_en && s.rb == r);
  endfunction

  logic alu_type_ok, mem_type_ok;

  assign intra_dep_o = alu_slot_i.wr_en && reads_reg(mem_slot_i, alu_slot_i.wr_reg);
  // second half of a split follows an ALU-only cycle, so no load is pending
  assign load_use_o  = ld_v_i && !split_q_i &&
                       (reads_reg(alu_slot_i, ld_reg_i) || reads_reg(mem_slot_i, ld_reg_i));

  assign alu_type_ok = alu_slot_i.cls inside {CLS_NOP, CLS_ALU, CLS_BR};
  assign mem_type_ok = mem_slot_i.cls inside {CLS_NOP, CLS_LD, CLS_ST};
  assign illegal_o   = !(alu_type_ok && mem_type_ok);
endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import dual_issue_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_valid_i,
  input  logic              alu_nop_i,
  input  logic              mem_nop_i,
  input  logic              mem_ld_wr_i,
  input  logic [REG_AW-1:0] mem_ld_reg_i,
  input  logic              intra_dep_i,
  input  logic              load_use_i,
  output logic              issue_alu_o,
  output logic              issue_mem_o,
  output logic              hold_o,
  output logic [PC_W-1:0]   pc_adv_o,
  output logic              split_q_o,
  output logic              ld_v_o,
  output logic [REG_AW-1:0] ld_reg_o
);
  logic              split_q, split_d;
  logic              ld_v_q, ld_v_d;
  logic [REG_AW-1:0] ld_reg_q, ld_reg_d;
  logic              do_split;

  assign do_split = pkt_valid_i && !load_use_i && !split_q && intra_dep_i;

  always_comb begin
    issue_alu_o = 1'b0;
    issue_mem_o = 1'b0;
    hold_o      = 1'b0;
    if (pkt_valid_i) begin
      if (load_use_i) begin
        hold_o = 1'b1;
      end else if (split_q) begin
        issue_mem_o = !mem_nop_i;
      end else if (intra_dep_i) begin
        issue_alu_o = !alu_nop_i;
        hold_o      = 1'b1;
      end else begin
        issue_alu_o = !alu_nop_i;
        issue_mem_o = !mem_nop_i;
      end
    end
  end

  assign pc_adv_o = (pkt_valid_i && !hold_o) ? PC_W'(PC_STEP) : '0;

  always_comb begin
    split_d = split_q;
    if (do_split)                    split_d = 1'b1;
    else if (split_q && pkt_valid_i) split_d = 1'b0;
    ld_v_d   = issue_mem_o && mem_ld_wr_i;
    ld_reg_d = ld_v_d ? mem_ld_reg_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      split_q  <= 1'b0;
      ld_v_q   <= 1'b0;
      ld_reg_q <= '0;
    end else begin
      split_q  <= split_d;
      ld_v_q   <= ld_v_d;
      ld_reg_q <= ld_reg_d;
    end
  end

  assign split_q_o = split_q;
  assign ld_v_o    = ld_v_q;
  assign ld_reg_o  = ld_reg_q;
endmodule

// File: rtl/dual_issue_ctrl.sv
module dual_issue_ctrl
  import dual_issue_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_valid_i,
  input  logic [PKT_W-1:0] pkt_i,
  output logic             issue_alu_o,
  output logic             issue_mem_o,
  output logic             hold_o,
  output logic [PC_W-1:0]  pc_adv_o,
  output logic             illegal_o
);
  slot_info_t        info [N_SLOT];
  logic              intra_dep, load_use, bad_mix;
  logic              split_q, ld_v;
  logic [REG_AW-1:0] ld_reg;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_dec
    slot_decoder u_dec (
      .instr_i (pkt_i[g*INSTR_W +: INSTR_W]),
      .info_o  (info[g])
    );
  end

  hazard_unit u_haz (
    .alu_slot_i  (info[0]),
    .mem_slot_i  (info[1]),
    .ld_v_i      (ld_v),
    .ld_reg_i    (ld_reg),
    .split_q_i   (split_q),
    .intra_dep_o (intra_dep),
    .load_use_o  (load_use),
    .illegal_o   (bad_mix)
  );

  issue_ctrl u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pkt_valid_i  (pkt_valid_i),
    .alu_nop_i    (info[0].cls == CLS_NOP),
    .mem_nop_i    (info[1].cls == CLS_NOP),
    .mem_ld_wr_i  (info[1].cls == CLS_LD && info[1].wr_en),
    .mem_ld_reg_i (info[1].wr_reg),
    .intra_dep_i  (intra_dep),
    .load_use_i   (load_use),
    .issue_alu_o  (issue_alu_o),
    .issue_mem_o  (issue_mem_o),
    .hold_o       (hold_o),
    .pc_adv_o     (pc_adv_o),
    .split_q_o    (split_q),
    .ld_v_o       (ld_v),
    .ld_reg_o     (ld_reg)
  );

  assign illegal_o = pkt_valid_i && bad_mix;
endmodule

// File: rtl/dual_issue_ctrl_chk.sv
module dual_issue_ctrl_chk
  import dual_issue_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pkt_valid_i,
  input logic [PKT_W-1:0] pkt_i,
  input logic             issue_alu_o,
  input logic             issue_mem_o,
  input logic             hold_o,
  input logic [PC_W-1:0]  pc_adv_o,
  input logic             illegal_o
);
  logic lu_stall;
  assign lu_stall = pkt_valid_i && hold_o && !issue_alu_o && !issue_mem_o;

  assert_hold_no_adv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> pc_adv_o == '0);

  assert_full_adv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !hold_o) |-> pc_adv_o == PC_W'(PC_STEP));

  assert_split_alu_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && issue_alu_o) |-> !issue_mem_o);

  assert_split_second_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && hold_o && issue_alu_o) |=> !issue_alu_o);

  assert_lu_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lu_stall |=> !lu_stall);

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_i |-> (!issue_alu_o && !issue_mem_o && !hold_o && !illegal_o && pc_adv_o == '0));

  assert_nop_alu_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_i[INSTR_W-1:0] == '0) |-> !issue_alu_o);

  assert_nop_mem_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_i[PKT_W-1:INSTR_W] == '0) |-> !issue_mem_o);
endmodule

bind dual_issue_ctrl dual_issue_ctrl_chk u_chk (.*);

// File: tb/tb_dual_issue_ctrl.sv
module tb_dual_issue_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pkt_valid_i = 1'b0;
  logic [63:0] pkt_i = '0;
  logic        issue_alu_o, issue_mem_o, hold_o, illegal_o;
  logic [3:0]  pc_adv_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  bit       m_split = 0, m_ldv = 0;
  bit [4:0] m_ld = 0;
  int       cyc_cnt = 0, iss_cnt = 0, pc_sum = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dual_issue_ctrl dut (
    .clk_i, .rst_ni, .pkt_valid_i, .pkt_i,
    .issue_alu_o, .issue_mem_o, .hold_o, .pc_adv_o, .illegal_o
  );

  function automatic bit [31:0] r_ins(bit [4:0] rs, bit [4:0] rt, bit [4:0] rd);
    return {6'h00, rs, rt, rd, 5'd0, 6'h21};
  endfunction
  function automatic bit [31:0] i_ins(bit [5:0] op, bit [4:0] rs, bit [4:0] rt, bit [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic bit [4:0] m_dst(bit [31:0] i);
    bit [5:0] op = i[31:26];
    if (op == 6'h00) return i[15:11];
    if (op >= 6'h08 && op <= 6'h0F) return i[20:16];
    if (op == 6'h23) return i[20:16];
    return 5'd0;
  endfunction

  function automatic bit m_reads(bit [31:0] i, bit [4:0] r);
    bit [5:0] op = i[31:26];
    bit a = (i[25:21] == r), b = (i[20:16] == r);
    if (r == 0 || i == 0) return 0;
    case (op)
      6'h00, 6'h04, 6'h05, 6'h2B: return a || b;
      6'h01, 6'h06, 6'h07, 6'h23: return a;
      6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E: return a;
      default: return 0;
    endcase
  endfunction

  function automatic bit alu_ok(bit [31:0] i);
    bit [5:0] op = i[31:26];
    return i == 0 || op == 6'h00 || op == 6'h01 || (op >= 6'h04 && op <= 6'h0F);
  endfunction
  function automatic bit mem_ok(bit [31:0] i);
    return i == 0 || i[31:26] == 6'h23 || i[31:26] == 6'h2B;
  endfunction

  task automatic check(string req, bit [7:0] act, bit [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive, compare with model, let the edge happen
  task automatic step(bit v, bit [63:0] p, string req, output bit hold);
    bit [31:0] s0 = p[31:0], s1 = p[63:32];
    bit ea = 0, em = 0, eh = 0, ei = 0, lu, dep;
    bit [3:0] ep = 0;
    bit [4:0] d;
    @(negedge clk_i);
    pkt_valid_i = v;
    pkt_i = p;
    #(CLK_PERIOD/4);
    lu  = !m_split && m_ldv && (m_reads(s0, m_ld) || m_reads(s1, m_ld));
    d   = m_dst(s0);
    dep = d != 0 && m_reads(s1, d);
    if (v) begin
      ei = !(alu_ok(s0) && mem_ok(s1));
      if (lu) eh = 1;
      else if (m_split) begin em = s1 != 0; m_split = 0; end
      else if (dep) begin ea = s0 != 0; eh = 1; m_split = 1; end
      else begin ea = s0 != 0; em = s1 != 0; end
      if (!eh) ep = 4'd8;
    end
    check(req, {illegal_o, issue_alu_o, issue_mem_o, hold_o, pc_adv_o},
               {ei, ea, em, eh, ep});
    m_ldv = em && s1[31:26] == 6'h23 && s1[20:16] != 0;
    m_ld  = s1[20:16];
    hold  = eh;
    cyc_cnt++;
    iss_cnt += int'(issue_alu_o) + int'(issue_mem_o);
    pc_sum  += int'(pc_adv_o);
  endtask

  // present a packet until fetch may move on
  task automatic present(bit [63:0] p, string req);
    bit h;
    do step(1'b1, p, req, h); while (h);
  endtask

  task automatic bubble(string req);
    bit h;
    step(1'b0, 64'h0, req, h);
  endtask

  function automatic bit [31:0] rnd_ins(int kind);
    bit [4:0] a = 5'($urandom % 4), b = 5'($urandom % 4), c = 5'($urandom % 4);
    case (kind)
      1: return r_ins(a, b, c);
      2: return i_ins(6'h08, a, b, 16'h0004);
      3: return i_ins(6'h04, a, b, 16'hFFF0);
      4: return i_ins(6'h23, a, b, 16'h0010);
      5: return i_ins(6'h2B, a, b, 16'h0020);
      6: return i_ins(6'h03, a, b, 16'h0000);
      default: return 32'h0;
    endcase
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    bit [63:0] lp [8];
    bit h;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk_i);
    // R8: reset clears state; idle with no packet
    #(CLK_PERIOD/4);
    check("R8", {illegal_o, issue_alu_o, issue_mem_o, hold_o, pc_adv_o}, 8'h0);
    rst_ni = 1'b1;

    // R3 no hazard, R1 nop slot
    present({i_ins(6'h23, 5'd1, 5'd2, 16'h0), r_ins(5'd3, 5'd4, 5'd5)}, "R3");
    present({32'h0, r_ins(5'd3, 5'd4, 5'd6)}, "R1");
    // R4 split on base register
    present({i_ins(6'h23, 5'd7, 5'd8, 16'h0), i_ins(6'h08, 5'd1, 5'd7, 16'h4)}, "R4");
    // R4 split on store data register
    present({i_ins(6'h2B, 5'd1, 5'd9, 16'h0), r_ins(5'd2, 5'd3, 5'd9)}, "R4");
    // R5 load-use in the next packet
    present({i_ins(6'h23, 5'd1, 5'd10, 16'h0), 32'h0}, "R5");
    present({32'h0, r_ins(5'd10, 5'd2, 5'd11)}, "R5");
    // R9 branch read of load destination stalls
    present({i_ins(6'h23, 5'd1, 5'd12, 16'h0), 32'h0}, "R9");
    present({32'h0, i_ins(6'h05, 5'd12, 5'd0, 16'hFFF8)}, "R9");
    // R7 bubble covers load latency
    present({i_ins(6'h23, 5'd1, 5'd13, 16'h0), 32'h0}, "R7");
    bubble("R7");
    present({32'h0, r_ins(5'd13, 5'd2, 5'd14)}, "R7");
    // R6 r0 never a dependency
    present({i_ins(6'h23, 5'd0, 5'd0, 16'h0), r_ins(5'd1, 5'd2, 5'd0)}, "R6");
    present({32'h0, r_ins(5'd0, 5'd0, 5'd3)}, "R6");
    // R2 illegal slot types still issue
    present({r_ins(5'd1, 5'd2, 5'd3), i_ins(6'h23, 5'd4, 5'd5, 16'h0)}, "R2");
    present({i_ins(6'h02, 5'd0, 5'd0, 16'h0), 32'h0}, "R2");

    // unrolled loop, 8 packets, one planned split: 9 cycles, 14 issues
    lp[0] = {i_ins(6'h23, 5'd17, 5'd8,  16'd0),  32'h0};
    lp[1] = {i_ins(6'h23, 5'd17, 5'd9,  16'd4),  32'h0};
    lp[2] = {i_ins(6'h23, 5'd17, 5'd10, 16'd8),  r_ins(5'd8,  5'd18, 5'd8)};
    lp[3] = {i_ins(6'h23, 5'd17, 5'd11, 16'd12), r_ins(5'd9,  5'd18, 5'd9)};
    lp[4] = {i_ins(6'h2B, 5'd17, 5'd8,  16'd0),  r_ins(5'd10, 5'd18, 5'd10)};
    lp[5] = {i_ins(6'h2B, 5'd17, 5'd9,  16'd4),  r_ins(5'd11, 5'd18, 5'd11)};
    lp[6] = {i_ins(6'h2B, 5'd17, 5'd10, 16'hFFF8), i_ins(6'h08, 5'd17, 5'd17, 16'd16)};
    lp[7] = {i_ins(6'h2B, 5'd17, 5'd11, 16'hFFFC), i_ins(6'h05, 5'd17, 5'd19, 16'hFFE0)};
    for (int it = 0; it < 2; it++) begin
      cyc_cnt = 0; iss_cnt = 0; pc_sum = 0;
      for (int k = 0; k < 8; k++) present(lp[k], "R4");
      check("R3 loop cycles", 8'(cyc_cnt), 8'd9);
      check("R3 loop issues", 8'(iss_cnt), 8'd14);
      check("R3 loop pc", 8'(pc_sum), 8'd64);
    end

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int k0 = $urandom % 4, k1 = ($urandom % 3 == 0) ? 0 : 4 + $urandom % 2;
      if ($urandom % 20 == 0) k0 = 4 + $urandom % 3;
      if ($urandom % 20 == 0) k1 = 1 + $urandom % 2;
      if ($urandom % 10 == 0) bubble("R7");
      else present({rnd_ins(k1), rnd_ins(k0)}, "R4/R5 random");
    end

    // R8: reset mid-split drops the pending half
    step(1'b1, {i_ins(6'h23, 5'd2, 5'd3, 16'h0), r_ins(5'd1, 5'd1, 5'd2)}, "R4", h);
    @(negedge clk_i);
    pkt_valid_i = 0;
    rst_ni = 0;
    m_split = 0; m_ldv = 0;
    @(negedge clk_i);
    rst_ni = 1;
    present({i_ins(6'h23, 5'd2, 5'd3, 16'h0), r_ins(5'd1, 5'd1, 5'd2)}, "R8");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule